// File: doc/BRIEF.md
# CAN protocol event status recorder

This block holds the protocol status word that a host CPU polls to learn what the CAN bit engine has seen on the bus. The engine sends it single-cycle strobes: one per error type, a frame-success strobe, a flag for a stuff fault on a fixed stuff bit of an FD CRC field, and a level that is high while an FD frame with bit-rate switching is in its fast data phase. The block keeps one 3-bit error code for the nominal phase and a second for the fast data phase. It also registers the node activity code and the error-passive flag so that the host can read them.

An event that arrives while the data-phase flag is high is written to the data-phase code. All other events are written to the nominal code. Each host read returns the stored word. On the next cycle the read sets both code fields to "no change" (7), so the host can tell whether anything new has happened since its previous read. The read port is a plain strobe with no back-pressure: `rd_data` always shows the stored word, and `rd_en` only triggers the side effect.

Top module: `canstat_recorder`

## Requirements
- R1: After reset, `rd_data` reads 0x03F: both code fields are 7, the activity field is 00 and the error-passive bit is 0.
- R2: `err_vec` bit i reports error code i+1. Bit 0 is stuff (1), bit 1 form (2), bit 2 ack (3), bit 3 bit1 (4), bit 4 bit0 (5) and bit 5 CRC (6). A single strobe stores its code in the selected field one cycle later.
- R3: A `frame_ok` strobe with no error strobe in the same cycle stores 0 in the selected field.
- R4: When several error strobes assert in one cycle, the lowest code among them is stored. Any error strobe takes precedence over `frame_ok` in the same cycle.
- R5: A stuff strobe with `fixed_stuff` high is stored as form error (2), not as stuff error (1).
- R6: An event whose cycle has `brs_data` high is written to the data-phase field `rd_data[5:3]`, and the nominal field `rd_data[2:0]` is left unchanged. With `brs_data` low, the event goes to the nominal field and the data-phase field is left unchanged.
- R7: In the cycle `rd_en` is high, `rd_data` shows the word held before the read. From the next cycle on, both code fields read 7.
- R8: If an event and `rd_en` fall in the same cycle, the field that receives the event takes the event code and not 7. The other field still becomes 7.
- R9: `rd_data[7:6]` shows `act_in` and `rd_data[8]` shows `err_passive` as sampled on the previous clock edge. The activity encoding is 00 synchronizing, 01 idle, 10 receiver, 11 transmitter.
- R10: In a cycle with neither an event nor a read, both code fields keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_vec | input | 6 | Error type strobes; bit i means code i+1 |
| fixed_stuff | input | 1 | The stuff strobe concerns a fixed stuff bit of an FD CRC field |
| frame_ok | input | 1 | Frame sent or received without error |
| brs_data | input | 1 | Fast data phase of a frame with bit-rate switching |
| act_in | input | 2 | Node activity code |
| err_passive | input | 1 | 1 when the node is error-passive |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 9 | {passive, activity, data-phase code, nominal code} |

## Verification
The bench builds the block with its default parameters: six error strobes and 3-bit codes. With these values the full input space of a single event is small enough to enumerate. The bench steps through all 64 strobe patterns, combined with every setting of `fixed_stuff`, `frame_ok`, `brs_data` and `rd_en`. Before each step it preloads both fields with distinct codes, so it can see which field was written and whether a read in the same cycle was overridden. A separate pass walks every activity code and both passive levels.

// File: rtl/canstat_pkg.sv
package canstat_pkg;
  localparam int CODE_W  = 3;
  localparam int NUM_ERR = 6;
  localparam int ACT_W   = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 3'd0,
    CODE_STUFF = 3'd1,
    CODE_FORM  = 3'd2,
    CODE_ACK   = 3'd3,
    CODE_BIT1  = 3'd4,
    CODE_BIT0  = 3'd5,
    CODE_CRC   = 3'd6,
    CODE_NOCHG = 3'd7
  } code_e;
endpackage

// File: rtl/canstat_err_pick.sv
module canstat_err_pick #(
  parameter int NUM_ERR = canstat_pkg::NUM_ERR,
  parameter int CODE_W  = canstat_pkg::CODE_W
) (
  input  logic [NUM_ERR-1:0] err_vec,
  input  logic               fixed_stuff,
  output logic               hit,
  output logic [CODE_W-1:0]  code
);
  import canstat_pkg::*;

  localparam logic [CODE_W-1:0] NOCHG = {CODE_W{1'b1}};

  // Lowest set strobe wins; scan downward so the last write is the lowest index.
  always_comb begin
    hit  = |err_vec;
    code = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (err_vec[i]) code = CODE_W'(i + 1);
    end
    if (err_vec[0] && fixed_stuff) code = CODE_W'(CODE_FORM);
  end

  always_comb begin
    if (hit) begin
      a_r4_code_in_range: assert (code != '0 && code != NOCHG);
      // R5: fixed stuff bit fault in the CRC field is reported as form error
      a_r5_fixed_stuff_form: assert (!(err_vec[0] && fixed_stuff) || code == CODE_W'(CODE_FORM));
    end
  end
endmodule

// File: rtl/canstat_code_reg.sv
module canstat_code_reg #(
  parameter int CODE_W = canstat_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              rd_clr,
  output logic [CODE_W-1:0] q
);
  localparam logic [CODE_W-1:0] NOCHG = {CODE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= NOCHG;
    else if (ev_valid) q <= ev_code;
    else if (rd_clr)   q <= NOCHG;
  end

  a_r7_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !ev_valid |=> q == NOCHG);
  a_r8_event_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> q == $past(ev_code));
  a_r10_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid && !rd_clr |=> $stable(q));
endmodule

// File: rtl/canstat_recorder.sv
module canstat_recorder #(
  parameter int NUM_ERR = canstat_pkg::NUM_ERR,
  parameter int CODE_W  = canstat_pkg::CODE_W,
  parameter int ACT_W   = canstat_pkg::ACT_W,
  localparam int RD_W   = 2 * CODE_W + ACT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] err_vec,
  input  logic               fixed_stuff,
  input  logic               frame_ok,
  input  logic               brs_data,
  input  logic [ACT_W-1:0]   act_in,
  input  logic               err_passive,
  input  logic               rd_en,
  output logic [RD_W-1:0]    rd_data
);
  localparam int NUM_FIELD = 2;  // 0: nominal phase, 1: fast data phase

  logic              err_hit;
  logic [CODE_W-1:0] err_code;
  logic              ev_any;
  logic [CODE_W-1:0] ev_code;
  logic [CODE_W-1:0] field_q [NUM_FIELD];
  logic [ACT_W-1:0]  act_q;
  logic              pas_q;

  canstat_err_pick #(.NUM_ERR(NUM_ERR), .CODE_W(CODE_W)) u_pick (
    .err_vec     (err_vec),
    .fixed_stuff (fixed_stuff),
    .hit         (err_hit),
    .code        (err_code)
  );

  assign ev_any  = err_hit | frame_ok;
  assign ev_code = err_hit ? err_code : '0;

  for (genvar f = 0; f < NUM_FIELD; f++) begin : g_field
    canstat_code_reg #(.CODE_W(CODE_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ev_any && (brs_data == (f == 1))),
      .ev_code  (ev_code),
      .rd_clr   (rd_en),
      .q        (field_q[f])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      pas_q <= 1'b0;
    end else begin
      act_q <= act_in;
      pas_q <= err_passive;
    end
  end

  assign rd_data = {pas_q, act_q, field_q[1], field_q[0]};

  a_r6_nominal_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any && brs_data && !rd_en |=> $stable(rd_data[CODE_W-1:0]));
  a_r6_data_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any && !brs_data && !rd_en |=> $stable(rd_data[2*CODE_W-1:CODE_W]));
  a_r3_success_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && !(|err_vec) && !brs_data |=> rd_data[CODE_W-1:0] == '0);
  a_r9_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_data[RD_W-1:2*CODE_W] == {$past(err_passive), $past(act_in)});
endmodule

// File: tb/canstat_recorder_tb.sv
module canstat_recorder_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] err_vec = '0;
  logic       fixed_stuff = 1'b0, frame_ok = 1'b0, brs_data = 1'b0;
  logic [1:0] act_in = '0;
  logic       err_passive = 1'b0, rd_en = 1'b0;
  logic [8:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canstat_recorder u_dut (
    .clk(clk), .rst_n(rst_n), .err_vec(err_vec), .fixed_stuff(fixed_stuff),
    .frame_ok(frame_ok), .brs_data(brs_data), .act_in(act_in),
    .err_passive(err_passive), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    err_vec = '0; fixed_stuff = 1'b0; frame_ok = 1'b0; brs_data = 1'b0; rd_en = 1'b0;
  endtask

  // One event for one cycle, then back to idle at the next falling edge.
  task automatic pulse(input logic [5:0] ev, input logic fx, input logic ok,
                       input logic brs, input logic rd);
    err_vec = ev; fixed_stuff = fx; frame_ok = ok; brs_data = brs; rd_en = rd;
    @(negedge clk);
    idle_inputs();
  endtask

  function automatic logic [2:0] exp_code(input logic [5:0] ev, input logic fx);
    logic [2:0] c = 3'd0;
    for (int i = 5; i >= 0; i--) if (ev[i]) c = 3'(i + 1);
    if (ev[0] && fx) c = 3'd2;
    return c;
  endfunction

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset word", rd_data, 9'h03F);
    @(negedge clk);
    chk("R10 quiet hold after reset", rd_data, 9'h03F);

    // Sweep every strobe pattern with every flag setting.
    for (int v = 0; v < 64; v++) begin
      for (int m = 0; m < 16; m++) begin
        logic fx, ok, brs, rd, ev_any;
        logic [2:0] nom, dat, code;
        logic [8:0] pre;
        fx = m[0]; ok = m[1]; brs = m[2]; rd = m[3];
        // Preload: nominal = ack (3), data phase = bit0 (5).
        pulse(6'b000100, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse(6'b010000, 1'b0, 1'b0, 1'b1, 1'b0);
        pre = {1'b0, 2'b00, 3'd5, 3'd3};
        err_vec = 6'(v); fixed_stuff = fx; frame_ok = ok; brs_data = brs; rd_en = rd;
        if (rd) chk("R7 read returns held word", rd_data, pre);
        @(negedge clk);
        idle_inputs();
        ev_any = (v != 0) || ok;
        code = exp_code(6'(v), fx);
        nom = rd ? 3'd7 : 3'd3;
        dat = rd ? 3'd7 : 3'd5;
        if (ev_any && !brs) nom = code;
        if (ev_any && brs)  dat = code;
        if (rd && ev_any)             chk("R8 event beats read", rd_data, {3'b000, dat, nom});
        else if (rd)                  chk("R7 read rearms to 7", rd_data, {3'b000, dat, nom});
        else if (!ev_any)             chk("R10 quiet hold", rd_data, {3'b000, dat, nom});
        else if ($countones(v) > 1)   chk("R4 lowest code wins", rd_data, {3'b000, dat, nom});
        else if (v == 1 && fx)        chk("R5 fixed stuff as form", rd_data, {3'b000, dat, nom});
        else if (v == 0)              chk("R3 success clears", rd_data, {3'b000, dat, nom});
        else if (brs)                 chk("R6 data-phase routing", rd_data, {3'b000, dat, nom});
        else                          chk("R2 single code", rd_data, {3'b000, dat, nom});
        if (ok && v != 0 && !rd)      chk("R4 error over success", rd_data, {3'b000, dat, nom});
      end
    end

    // Status fields: every activity code and both passive levels.
    for (int s = 0; s < 8; s++) begin
      act_in = 2'(s); err_passive = s[2];
      chk("R9 status lags one edge", rd_data[8:6], (s == 0) ? 3'b000 : {1'(s - 1 >> 2), 2'(s - 1)});
      @(negedge clk);
      chk("R9 status registered", rd_data[8:6], {s[2], 2'(s)});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule